// File: doc/BRIEF.md
# Stereo Pair Sync Error Detector

This block watches two byte lanes that a master image sensor and a slave image sensor are expected to emit in lockstep. A set of byte values is reserved for synchronisation codes. When the master lane carries one of these reserved values and the slave lane in the same beat does not, the two sensors have drifted apart. The block then raises an error flag and stores both bytes of that beat in a 16-bit diagnostic register.

The two lanes share one valid strobe. The block accepts every beat: `in_ready` is always high, so it never applies back-pressure. A beat with `in_valid` low is ignored. A small control port holds three bits. An enable bit gates detection. A sticky bit selects whether the flag latches or follows the comparison. A clear bit removes a latched flag. The flag is visible both as a status output and as a dedicated error pin.

Top module: `stereo_sync_err_det`

## Requirements
- R1: After reset the error flag, the error pin, the capture register and the control readback are all 0.
- R2: A byte counts as reserved when it equals any entry of the parameter set RES_VALUES. The default set is 8'h00 and 8'hFF, and every other value is non-reserved.
- R3: A mismatch occurs on a beat where `in_valid` is 1, detection is enabled, the master byte is reserved and the slave byte is not. The flag is 1 in the cycle after such a beat.
- R4: While the enable bit (cfg bit 0) is 0, no beat produces a mismatch and the capture register keeps its value.
- R5: On a mismatch beat, the capture register loads {master byte, slave byte}, with the master byte in bits 15:8. On any other beat it holds its value.
- R6: With the sticky bit (cfg bit 1) at 0, the flag in each cycle equals whether the previous beat was a mismatch.
- R7: With the sticky bit at 1, a set flag stays set until a clear is written.
- R8: A write with cfg bit 2 set clears the flag at that clock edge. Bit 2 is a one-cycle pulse that is never stored, so it always reads back as 0.
- R9: If a clear and a mismatch fall on the same edge, the flag ends up set.
- R10: `err_pin` always equals `err_flag`.
- R11: `in_ready` is constantly 1, and a beat with `in_valid` low never causes a mismatch.
- R12: A control write updates the enable and sticky bits at its clock edge. The new values govern beats from the next cycle on and read back on `cfg_rdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Both lanes carry a beat |
| in_ready | output | 1 | Always 1; the block never stalls |
| mst_byte | input | W | Master lane byte |
| slv_byte | input | W | Slave lane byte |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Bit 0 enable, bit 1 sticky, bit 2 clear pulse |
| cfg_rdata | output | 3 | Stored enable and sticky bits; bit 2 reads 0 |
| err_flag | output | 1 | Error status |
| err_pin | output | 1 | Error output pin, a copy of the flag |
| capture | output | 2*W | {master, slave} bytes of the last mismatch |

## Verification
The assertions assume that the two lanes only carry meaning while `in_valid` is high, and that control writes are single-cycle strobes whose enable and sticky bits take effect one edge later. The assertions compute the reserved test from the parameter set independently of the matcher. The stimulus changes inputs only at falling edges and holds each beat for exactly one cycle. It sweeps every slave value against reserved and non-reserved master bytes, and every master value against a fixed slave byte. Clear writes are issued both alone and on the same beat as a mismatch.

// File: rtl/stereo_sync_pkg.sv
package stereo_sync_pkg;
  localparam int CFG_BITS  = 3;
  localparam int CFG_EN    = 0;
  localparam int CFG_STICK = 1;
  localparam int CFG_CLR   = 2;

  typedef struct packed {
    logic sticky;
    logic enable;
  } ctl_t;
endpackage

// File: rtl/stereo_sync_ctl.sv
module stereo_sync_ctl
  import stereo_sync_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CFG_BITS-1:0] wdata,
  output ctl_t                ctl,
  output logic                clr_pulse,
  output logic [CFG_BITS-1:0] rdata
);
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q.enable <= wdata[CFG_EN];
      ctl_q.sticky <= wdata[CFG_STICK];
    end
  end

  assign ctl       = ctl_q;
  assign clr_pulse = we & wdata[CFG_CLR];

  always_comb begin
    rdata            = '0;
    rdata[CFG_EN]    = ctl_q.enable;
    rdata[CFG_STICK] = ctl_q.sticky;
  end
endmodule

// File: rtl/stereo_sync_match.sv
module stereo_sync_match #(
  parameter int                   W          = 8,
  parameter int                   RES_COUNT  = 2,
  parameter logic [RES_COUNT*W-1:0] RES_VALUES = 16'hFF00
) (
  input  logic [W-1:0] byte_i,
  output logic         reserved
);
  logic [RES_COUNT-1:0] hit;

  for (genvar g = 0; g < RES_COUNT; g++) begin : g_cmp
    assign hit[g] = (byte_i == RES_VALUES[g*W +: W]);
  end

  assign reserved = |hit;
endmodule

// File: rtl/stereo_sync_err_det.sv
module stereo_sync_err_det
  import stereo_sync_pkg::*;
#(
  parameter int                   W          = 8,
  parameter int                   RES_COUNT  = 2,
  parameter logic [RES_COUNT*W-1:0] RES_VALUES = 16'hFF00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        mst_byte,
  input  logic [W-1:0]        slv_byte,
  input  logic                cfg_we,
  input  logic [CFG_BITS-1:0] cfg_wdata,
  output logic [CFG_BITS-1:0] cfg_rdata,
  output logic                err_flag,
  output logic                err_pin,
  output logic [2*W-1:0]      capture
);
  localparam int CW = 2 * W;

  ctl_t          ctl;
  logic          clr_pulse;
  logic          mst_res, slv_res, mismatch;
  logic          flag_q;
  logic [CW-1:0] cap_q;

  stereo_sync_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .ctl       (ctl),
    .clr_pulse (clr_pulse),
    .rdata     (cfg_rdata)
  );

  stereo_sync_match #(.W(W), .RES_COUNT(RES_COUNT), .RES_VALUES(RES_VALUES)) u_mst (
    .byte_i   (mst_byte),
    .reserved (mst_res)
  );

  stereo_sync_match #(.W(W), .RES_COUNT(RES_COUNT), .RES_VALUES(RES_VALUES)) u_slv (
    .byte_i   (slv_byte),
    .reserved (slv_res)
  );

  assign in_ready = 1'b1;
  assign mismatch = in_valid & ctl.enable & mst_res & ~slv_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (mismatch)       flag_q <= 1'b1;
      else if (clr_pulse) flag_q <= 1'b0;
      else                flag_q <= ctl.sticky & flag_q;
      if (mismatch) cap_q <= {mst_byte, slv_byte};
    end
  end

  assign err_flag = flag_q;
  assign err_pin  = flag_q;
  assign capture  = cap_q;
endmodule

// File: rtl/stereo_sync_err_det_chk.sv
module stereo_sync_err_det_chk #(
  parameter int                   W          = 8,
  parameter int                   RES_COUNT  = 2,
  parameter logic [RES_COUNT*W-1:0] RES_VALUES = 16'hFF00
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   mst_byte,
  input logic [W-1:0]   slv_byte,
  input logic           cfg_we,
  input logic [2:0]     cfg_wdata,
  input logic [2:0]     cfg_rdata,
  input logic           err_flag,
  input logic           err_pin,
  input logic [2*W-1:0] capture
);
  function automatic logic is_res(input logic [W-1:0] b);
    logic r = 1'b0;
    for (int i = 0; i < RES_COUNT; i++)
      if (b == RES_VALUES[i*W +: W]) r = 1'b1;
    return r;
  endfunction

  logic mm;
  assign mm = in_valid && cfg_rdata[0] && is_res(mst_byte) && !is_res(slv_byte);

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n) mm |=> err_flag);
  p_capture_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mm |=> capture == {$past(mst_byte), $past(slv_byte)});
  p_capture_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) !mm |=> $stable(capture));
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[0] && !err_flag) |=> !err_flag);
  p_live_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[1] && !mm) |=> !err_flag);
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1] && err_flag && !(cfg_we && cfg_wdata[2])) |=> err_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2] && !mm) |=> !err_flag);
  p_clear_loses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2] && mm) |=> err_flag);
  p_pin_copy_r10: assert property (@(posedge clk) disable iff (!rst_n) err_pin == err_flag);
endmodule

bind stereo_sync_err_det stereo_sync_err_det_chk #(
  .W(W), .RES_COUNT(RES_COUNT), .RES_VALUES(RES_VALUES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mst_byte(mst_byte),
  .slv_byte(slv_byte), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .err_flag(err_flag), .err_pin(err_pin), .capture(capture)
);

// File: tb/stereo_sync_err_det_test.sv
module stereo_sync_err_det_test;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  mst_byte = '0, slv_byte = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic [2:0]  cfg_rdata;
  logic        err_flag, err_pin;
  logic [15:0] capture;

  int compared = 0, mismatched = 0;
  logic        r_en = 0, r_st = 0, r_flag = 0;
  logic [15:0] r_cap = '0;
  bit          done = 0;

  always #HALF clk = ~clk;

  stereo_sync_err_det uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mst_byte(mst_byte), .slv_byte(slv_byte), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_flag(err_flag),
    .err_pin(err_pin), .capture(capture)
  );

  function automatic bit rsv(input logic [7:0] b);
    return (b == 8'd0) || (b == 8'd255);
  endfunction

  task automatic check(input string tag);
    logic [21:0] act, exp;
    act = {in_ready, cfg_rdata, err_flag, err_pin, capture};
    exp = {1'b1, 1'b0, r_st, r_en, r_flag, r_flag, r_cap};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (rdy,rd,flag,pin,cap)", tag, act, exp);
    end
  endtask

  // Drive one beat at the falling edge, step the reference, compare at the next falling edge.
  task automatic beat(input logic v, input logic [7:0] m, input logic [7:0] s,
                      input logic we, input logic [2:0] wd, input string tag);
    bit mm;
    in_valid = v; mst_byte = m; slv_byte = s; cfg_we = we; cfg_wdata = wd;
    mm = v && r_en && rsv(m) && !rsv(s);
    if (mm) r_flag = 1;
    else if (we && wd[2]) r_flag = 0;
    else r_flag = r_st && r_flag;
    if (mm) r_cap = {m, s};
    if (we) begin r_en = wd[0]; r_st = wd[1]; end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] mlist [6] = '{8'h00, 8'hFF, 8'h01, 8'h7F, 8'h80, 8'hFE};
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");
    // R12: enable written alongside a mismatch beat: not yet active
    beat(1, 8'h00, 8'h55, 1, 3'b001, "R12 write edge");
    beat(0, 8'h00, 8'h00, 0, 3'b000, "R12 readback");
    // R3 R5 R6 R2: sweep all slave values against reserved/plain masters
    foreach (mlist[i])
      for (int s = 0; s < 256; s++)
        beat(1, mlist[i], 8'(s), 0, 3'b000, "R3 R5 R6 slave sweep");
    // R2: sweep all master values against a plain slave
    for (int m = 0; m < 256; m++) beat(1, 8'(m), 8'h42, 0, 3'b000, "R2 master sweep");
    for (int m = 0; m < 256; m++) beat(1, 8'(m), 8'hFF, 0, 3'b000, "R2 slave reserved");
    // R11: invalid beats ignored
    for (int k = 0; k < 8; k++) beat(0, 8'hFF, 8'(k + 3), 0, 3'b000, "R11 invalid");
    // R4: disabled
    beat(1, 8'h00, 8'h11, 1, 3'b000, "R4 disable write");
    for (int k = 0; k < 16; k++) beat(1, 8'hFF, 8'(k * 7 + 1), 0, 3'b000, "R4 disabled");
    // R7 sticky
    beat(0, 8'h00, 8'h00, 1, 3'b011, "R12 sticky on");
    beat(1, 8'hFF, 8'h3C, 0, 3'b000, "R7 set");
    for (int k = 0; k < 10; k++) beat(1, 8'h10, 8'h00, 0, 3'b000, "R7 hold");
    // R8 clear, bit 2 never stored
    beat(0, 8'h00, 8'h00, 1, 3'b111, "R8 clear");
    beat(1, 8'h20, 8'h21, 0, 3'b000, "R8 stays clear");
    // R9 clear and mismatch together
    beat(1, 8'h00, 8'hA5, 1, 3'b111, "R9 collision");
    beat(1, 8'h33, 8'h33, 0, 3'b000, "R9 kept");
    // R6 back to live: flag falls
    beat(1, 8'h33, 8'h33, 1, 3'b001, "R6 live again");
    beat(1, 8'h33, 8'h33, 0, 3'b000, "R6 low");
    beat(1, 8'h00, 8'h5A, 0, 3'b000, "R10 pin high");
    beat(1, 8'h00, 8'h00, 0, 3'b000, "R10 pin low");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule